// File: doc/BRIEF.md
# Power-Up Strap Capture and Default Tuning-Word Loader

This block brings a frequency synthesizer out of power-up in a known, useful state before any register has been programmed over the configuration port. Once both supply-good flags are true, it produces an internal reset pulse whose length is set in clock cycles. During that pulse the four shared status/strap pads stop driving, so external pull resistors set their levels. On the clock edge where the pulse falls, the pad levels are latched into a 4-bit strap register.

The same edge loads a default tuning word into tuning-word register 0 through a one-cycle write strobe. No separate update event is needed. The word comes from an 8-entry ROM addressed by the low three strap bits. Strap bit 3 chooses the clock source: crystal with PLL multiplier, or a direct clock input. When the PLL path is chosen, a default multiplier value of 40 is presented. A manual reset input, or a supply flag that drops and then returns, repeats the whole sequence.

Top module: `strap_boot_loader`

## Requirements
- R1: While either supply-good flag (`hv_ok_i`, `lv_ok_i`) is low, the following outputs are all 0 one cycle after that edge: `rst_pulse_o`, `pad_oe_o`, `pad_out_o`, `strap_o`, `ftw_we_o`, `ftw_data_o`, `clk_direct_o` and `pll_mult_o`. No pulse starts until both flags are high.
- R2: `rst_pulse_o` rises after the first clock edge at which both supply flags are seen high. It stays high for exactly PULSE_CYC cycles when `ext_rst_i` stays low.
- R3: `ext_rst_i` is sampled only while both supplies are good and has no effect otherwise. When sampled high, the next edge raises (or holds) `rst_pulse_o`. The pulse then falls PULSE_CYC cycles after the last edge at which `ext_rst_i` was seen high.
- R4: `pad_oe_o` is low whenever `rst_pulse_o` is high. It rises one cycle after `rst_pulse_o` falls. It drops on the same edge that starts a manual reset pulse. `pad_out_o` is `status_i` delayed by one register.
- R5: `strap_o` takes the value of `pad_in_i` at the edge where `rst_pulse_o` falls. Pad changes at any other time leave `strap_o` unchanged.
- R6: `ftw_we_o` is high for exactly one cycle, on the same cycle that `strap_o` updates. At that point `ftw_data_o` equals the table word for strap bits [2:0] (bit 0 is the least significant). `ftw_data_o` holds that word afterwards.
- R7: Table entry 0 is 0. Entries 1 to 7 are round(f × 65536 / 1000), with f in MHz taken from this list: 38.87939, 51.83411, 61.43188, 77.75879, 92.14783, 122.87903, 155.51758. The entries rise with the index, and both clock modes share the table.
- R8: Strap bit 3 drives `clk_direct_o`: 0 selects crystal/PLL, 1 selects the direct clock. `pll_mult_o` is 40 in crystal/PLL mode and 0 in direct mode. Both update with `strap_o`.
- R9: A supply flag that drops and returns causes a fresh pulse of PULSE_CYC cycles, a new strap capture and a new default load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hv_ok_i | input | 1 | Higher-voltage supply good |
| lv_ok_i | input | 1 | Lower-voltage supply good |
| ext_rst_i | input | 1 | Manual reset request, active high |
| pad_in_i | input | 4 | Levels seen on the strap/status pads |
| status_i | input | 4 | Internal status to drive onto the pads |
| pad_out_o | output | 4 | Value driven onto the pads when enabled |
| pad_oe_o | output | 1 | Pad output enable |
| rst_pulse_o | output | 1 | Internal reset pulse |
| strap_o | output | 4 | Latched strap value |
| clk_direct_o | output | 1 | 1 = direct clock input, 0 = crystal/PLL |
| pll_mult_o | output | 6 | Default PLL multiplier |
| ftw_we_o | output | 1 | Write strobe for tuning-word register 0 |
| ftw_data_o | output | 16 | Default tuning word |

## Verification
A sequencer counter that is off by one shows up as a `rst_pulse_o` one cycle too short or too long. It also shifts `ftw_we_o` and the strap capture to the wrong edge, so pad values meant to be ignored get latched. These errors appear within the first pulse after power-up. A wrong ROM word or a swapped address bit appears on `ftw_data_o` in the cycle of the write strobe. Sweeping all sixteen strap values exposes it within one manual reset. A pad enable that lags the sequencer shows up as `pad_oe_o` high during a pulse, on the first cycle of a manual reset.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int STRAP_W = 4;
  localparam int ADDR_W  = STRAP_W - 1;
  localparam int FTW_W   = 16;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_PULSE = 2'd1,
    PH_RUN   = 2'd2
  } seq_state_t;

  // Default tuning words: round(f_MHz * 65536 / 1000) at a 1 GHz sample clock
  function automatic logic [FTW_W-1:0] default_word(input logic [ADDR_W-1:0] idx);
    logic [FTW_W-1:0] w;
    case (idx)
      3'd1:    w = 16'd2548;
      3'd2:    w = 16'd3397;
      3'd3:    w = 16'd4026;
      3'd4:    w = 16'd5096;
      3'd5:    w = 16'd6039;
      3'd6:    w = 16'd8053;
      3'd7:    w = 16'd10192;
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/strap_reset_seq.sv
module strap_reset_seq
  import strap_pkg::*;
#(
  parameter int PULSE_CYC = 8
) (
  input  logic clk,
  input  logic hv_ok_i,
  input  logic lv_ok_i,
  input  logic ext_rst_i,
  output logic pwr_off_o,
  output logic rst_pulse_o,
  output logic capture_o,
  output logic run_o
);
  localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_CYC - 1);

  seq_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pulse_q;

  assign pwr_off_o = !(hv_ok_i && lv_ok_i);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    capture_o = 1'b0;
    case (state_q)
      PH_OFF: begin
        state_d = PH_PULSE;
        cnt_d   = RELOAD;
      end
      PH_PULSE: begin
        if (ext_rst_i) begin
          cnt_d = RELOAD;
        end else if (cnt_q == '0) begin
          state_d   = PH_RUN;
          capture_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RUN: begin
        if (ext_rst_i) begin
          state_d = PH_PULSE;
          cnt_d   = RELOAD;
        end
      end
      default: begin
        state_d = PH_OFF;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (pwr_off_o) begin
      state_q <= PH_OFF;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pulse_q <= (state_d == PH_PULSE);
    end
  end

  assign rst_pulse_o = pulse_q;
  assign run_o       = (state_q == PH_RUN);

  a_r1_no_pulse_unpowered: assert property (@(posedge clk) pwr_off_o |=> !rst_pulse_o)
    else $error("R1: pulse while supplies bad");
  a_r2_pulse_after_power: assert property (@(posedge clk) disable iff (pwr_off_o)
    (state_q == PH_OFF) |=> rst_pulse_o)
    else $error("R2: no pulse after supplies good");
  a_r3_manual_pulse: assert property (@(posedge clk) disable iff (pwr_off_o)
    ext_rst_i |=> rst_pulse_o)
    else $error("R3: manual reset did not hold pulse");
  a_r5_capture_at_fall: assert property (@(posedge clk) disable iff (pwr_off_o)
    capture_o |=> !rst_pulse_o)
    else $error("R5: capture not at falling edge");
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               pwr_off_i,
  input  logic               capture_i,
  input  logic               run_i,
  input  logic               ext_rst_i,
  input  logic [STRAP_W-1:0] pad_in_i,
  input  logic [STRAP_W-1:0] status_i,
  output logic [STRAP_W-1:0] strap_o,
  output logic               pad_oe_o,
  output logic [STRAP_W-1:0] pad_out_o
);
  logic [STRAP_W-1:0] strap_q;
  logic               oe_q;
  logic [STRAP_W-1:0] pout_q;

  always_ff @(posedge clk) begin
    if (pwr_off_i) begin
      strap_q <= '0;
      oe_q    <= 1'b0;
      pout_q  <= '0;
    end else begin
      if (capture_i) strap_q <= pad_in_i;
      oe_q   <= run_i && !ext_rst_i;
      pout_q <= status_i;
    end
  end

  assign strap_o   = strap_q;
  assign pad_oe_o  = oe_q;
  assign pad_out_o = pout_q;

  a_r5_strap_hold: assert property (@(posedge clk) disable iff (pwr_off_i)
    !capture_i |=> $stable(strap_o))
    else $error("R5: strap changed outside capture");
  a_r4_oe_after_run: assert property (@(posedge clk) disable iff (pwr_off_i)
    !run_i |=> !pad_oe_o)
    else $error("R4: pads driven before run");
endmodule

// File: rtl/strap_default_loader.sv
module strap_default_loader
  import strap_pkg::*;
#(
  parameter int MULT_W   = 6,
  parameter int MULT_DEF = 40
) (
  input  logic               clk,
  input  logic               pwr_off_i,
  input  logic               capture_i,
  input  logic [STRAP_W-1:0] pad_in_i,
  output logic               ftw_we_o,
  output logic [FTW_W-1:0]   ftw_data_o,
  output logic               clk_direct_o,
  output logic [MULT_W-1:0]  pll_mult_o
);
  logic [ADDR_W-1:0] addr;
  logic              mode_bit;
  logic [FTW_W-1:0]  rom_q;
  logic              we_q;
  logic              dir_q;
  logic [MULT_W-1:0] mult_q;

  assign addr     = pad_in_i[ADDR_W-1:0];
  assign mode_bit = pad_in_i[STRAP_W-1];

  // Synchronous-read ROM: read enable is the capture edge
  always_ff @(posedge clk) begin
    if (pwr_off_i) begin
      rom_q <= '0;
    end else if (capture_i) begin
      rom_q <= default_word(addr);
    end
  end

  always_ff @(posedge clk) begin
    if (pwr_off_i) begin
      we_q   <= 1'b0;
      dir_q  <= 1'b0;
      mult_q <= '0;
    end else begin
      we_q <= capture_i;
      if (capture_i) begin
        dir_q  <= mode_bit;
        mult_q <= mode_bit ? '0 : MULT_W'(MULT_DEF);
      end
    end
  end

  assign ftw_we_o     = we_q;
  assign ftw_data_o   = rom_q;
  assign clk_direct_o = dir_q;
  assign pll_mult_o   = mult_q;

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (pwr_off_i)
    ftw_we_o |=> !ftw_we_o)
    else $error("R6: write strobe longer than one cycle");
  a_r6_word_hold: assert property (@(posedge clk) disable iff (pwr_off_i)
    !capture_i |=> $stable(ftw_data_o))
    else $error("R6: tuning word changed without load");
endmodule

// File: rtl/strap_boot_loader.sv
module strap_boot_loader
  import strap_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int MULT_W    = 6,
  parameter int MULT_DEF  = 40
) (
  input  logic               clk,
  input  logic               hv_ok_i,
  input  logic               lv_ok_i,
  input  logic               ext_rst_i,
  input  logic [STRAP_W-1:0] pad_in_i,
  input  logic [STRAP_W-1:0] status_i,
  output logic [STRAP_W-1:0] pad_out_o,
  output logic               pad_oe_o,
  output logic               rst_pulse_o,
  output logic [STRAP_W-1:0] strap_o,
  output logic               clk_direct_o,
  output logic [MULT_W-1:0]  pll_mult_o,
  output logic               ftw_we_o,
  output logic [FTW_W-1:0]   ftw_data_o
);
  logic pwr_off, capture, run;

  strap_reset_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
    .clk(clk), .hv_ok_i(hv_ok_i), .lv_ok_i(lv_ok_i), .ext_rst_i(ext_rst_i),
    .pwr_off_o(pwr_off), .rst_pulse_o(rst_pulse_o), .capture_o(capture), .run_o(run)
  );

  strap_latch u_latch (
    .clk(clk), .pwr_off_i(pwr_off), .capture_i(capture), .run_i(run),
    .ext_rst_i(ext_rst_i), .pad_in_i(pad_in_i), .status_i(status_i),
    .strap_o(strap_o), .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o)
  );

  strap_default_loader #(.MULT_W(MULT_W), .MULT_DEF(MULT_DEF)) u_load (
    .clk(clk), .pwr_off_i(pwr_off), .capture_i(capture), .pad_in_i(pad_in_i),
    .ftw_we_o(ftw_we_o), .ftw_data_o(ftw_data_o),
    .clk_direct_o(clk_direct_o), .pll_mult_o(pll_mult_o)
  );

  a_r4_no_drive_in_reset: assert property (@(posedge clk) disable iff (pwr_off)
    rst_pulse_o |-> !pad_oe_o)
    else $error("R4: pads driven during reset");
  a_r8_mode_follows_strap: assert property (@(posedge clk) disable iff (pwr_off)
    ftw_we_o |-> (clk_direct_o == strap_o[STRAP_W-1]))
    else $error("R8: clock mode differs from strap");
  a_r6_strobe_with_strap: assert property (@(posedge clk) disable iff (pwr_off)
    ftw_we_o |-> !rst_pulse_o)
    else $error("R6: load during reset");
endmodule

// File: tb/sim_strap_boot_loader.sv
module sim_strap_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;

  logic clk = 1'b0;
  logic hv = 1'b0, lv = 1'b0, ext = 1'b0;
  logic [3:0] pad = 4'h0, status = 4'h0;
  logic [3:0] pad_out, strap;
  logic pad_oe, pulse, dir, we;
  logic [5:0] mult;
  logic [15:0] ftw;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_boot_loader #(.PULSE_CYC(P)) u0 (
    .clk(clk), .hv_ok_i(hv), .lv_ok_i(lv), .ext_rst_i(ext),
    .pad_in_i(pad), .status_i(status), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .rst_pulse_o(pulse), .strap_o(strap), .clk_direct_o(dir), .pll_mult_o(mult),
    .ftw_we_o(we), .ftw_data_o(ftw)
  );

  function automatic int tbl(input int idx);
    real f[8];
    f = '{0.0, 38.87939, 51.83411, 61.43188, 77.75879, 92.14783, 122.87903, 155.51758};
    return $rtoi(f[idx] * 65536.0 / 1000.0 + 0.5);
  endfunction

  // Behavioural reference: phase 0 = unpowered, 1 = in reset, 2 = running
  int ph = 0, left = 0, prev;
  int e_pulse = 0, e_oe = 0, e_pout = 0, e_strap = 0, e_we = 0, e_ftw = 0, e_dir = 0, e_mult = 0;

  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (!(hv && lv)) begin
      ph = 0; left = 0; e_pulse = 0; e_oe = 0; e_pout = 0;
      e_strap = 0; e_we = 0; e_ftw = 0; e_dir = 0; e_mult = 0;
    end else begin
      prev = ph;
      e_we = 0;
      if (ph == 0) begin
        ph = 1; left = P - 1;
      end else if (ph == 1) begin
        if (ext) left = P - 1;
        else if (left == 0) begin
          ph = 2; e_strap = int'(pad); e_we = 1; e_ftw = tbl(int'(pad[2:0]));
          e_dir = int'(pad[3]); e_mult = pad[3] ? 0 : 40;
        end else left--;
      end else if (ext) begin
        ph = 1; left = P - 1;
      end
      e_pulse = (ph == 1);
      e_oe = (prev == 2 && !ext);
      e_pout = int'(status);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R2/R3 rst_pulse", int'(pulse), e_pulse);
      chk("R4 pad_oe", int'(pad_oe), e_oe);
      chk("R4 pad_out", int'(pad_out), e_pout);
      chk("R5 strap", int'(strap), e_strap);
      chk("R6 ftw_we", int'(we), e_we);
      chk("R6/R7 ftw_data", int'(ftw), e_ftw);
      chk("R8 clk_direct", int'(dir), e_dir);
      chk("R8 pll_mult", int'(mult), e_mult);
      if (!(hv && lv) && ph == 0) chk("R1 all cleared", int'(pulse) + int'(we) + int'(strap), 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
      finish_run();
    end
  end

  initial begin
    // R1: supplies off, then only one supply up; manual reset ignored
    step(4);
    hv = 1; ext = 1; step(3);
    ext = 0; pad = 4'h5; step(1);
    // R2: both supplies good, pulse, capture 5
    lv = 1; step(3);
    pad = 4'h2; step(2);
    pad = 4'h5; step(P + 4);
    // R5: pad changes while running ignored; R4 status passthrough
    for (int i = 0; i < 6; i++) begin
      pad = 4'(i * 3); status = 4'(15 - i); step(1);
    end
    // R3/R6/R7/R8: manual reset sweep over all strap values
    for (int v = 0; v < 16; v++) begin
      pad = ~4'(v); ext = 1; step(1);
      ext = 0; step(3);
      pad = 4'(v); step(P + 3);
    end
    // R3: long manual reset hold
    pad = 4'hB; ext = 1; step(12);
    ext = 0; step(P + 4);
    // R9: lower supply drops mid-run and returns
    lv = 0; ext = 1; step(3);
    ext = 0; lv = 1; pad = 4'h9; step(P + 4);
    // R9: higher supply drops mid-pulse
    ext = 1; step(1);
    ext = 0; step(3);
    hv = 0; step(2);
    hv = 1; pad = 4'h7; step(P + 5);
    finish_run();
  end
endmodule